// File: doc/BRIEF.md
# Gigabit Copper PHY Status Latches and Error Statistics

This block holds the sticky status bits and the error statistics that a gigabit copper PHY reports through its management registers. It watches single-cycle event inputs from the receive path and the master/slave resolution logic. It presents a link bit that latches low, fault bits that latch high, two saturating error counters and a master/slave configuration-fault flag. All of these clear when management reads them. A read is given as a one-cycle strobe for each register group.

The block also guards the link against a silent receiver. When no idle pattern has been seen for a programmable window of clock cycles, it marks link lock as lost and forces the qualified link low until idles return. The register-bus decode and the analog receive path sit outside this block.

Top module: `phy_status_latch`

## Requirements
- R1: `link_stat_o` latches low. Once the qualified link `link_o` is 0 on a clock edge, `link_stat_o` stays 0 until a status read. A status read reloads it with the current `link_o`, so it returns to 1 after a read while the link is up.
- R2: `rfault_o` and `jabber_o` latch high. Any cycle with `rfault_i` or `jabber_i` high sets the matching bit. It stays set until a status read (`rd_status_i`). On that read the bit is reloaded with the current input value.
- R3: `rx_err_cnt_o` is a 16-bit count of `rx_err_i` pulses. It stops at 0xFFFF and never wraps. `rd_rxerr_i` clears it.
- R4: `idle_err_cnt_o` is an 8-bit count of `idle_err_i` pulses. It stops at 0xFF and never wraps. `rd_msstat_i` clears it.
- R5: `ms_fault_o` sets on the clock edge that samples the 7th `ms_fail_i` pulse since the last clear. It stays 0 after only 6 pulses.
- R6: A cycle with `ms_conflict_i` high sets `ms_fault_o` on the next edge. This input marks both ends forced to the same master or slave role.
- R7: `ms_fault_o` clears on the edge after `rd_msstat_i`, `an_enable_i` or `an_done_i` is high, and a clear takes precedence over a set in that cycle. The same clear resets the failed-resolution count to zero, so a later single failure does not set the flag.
- R8: The watchdog counts edges on which `idle_seen_i` is low. When the count reaches `IDLE_WIN`, `lock_lost_o` goes to 1 and `link_o` is forced to 0. After `IDLE_WIN`-1 such edges, `lock_lost_o` is still 0. One edge with `idle_seen_i` high clears `lock_lost_o` and restarts the count.
- R9: A counter event arriving in the same cycle as that counter's clear strobe is kept. The counter reads 1 after that edge.
- R10: After reset, every latched bit, counter and flag, and `lock_lost_o`, is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up_i | input | 1 | Raw link state from the receive path |
| idle_seen_i | input | 1 | Idle pattern detected this cycle |
| rx_err_i | input | 1 | Receive error pulse |
| idle_err_i | input | 1 | Idle error pulse |
| rfault_i | input | 1 | Remote fault indication |
| jabber_i | input | 1 | Jabber indication |
| ms_fail_i | input | 1 | Failed master/slave resolution pulse |
| ms_conflict_i | input | 1 | Both ends forced to the same role |
| an_enable_i | input | 1 | Auto-negotiation enable event |
| an_done_i | input | 1 | Auto-negotiation complete event |
| rd_status_i | input | 1 | Read strobe for link and fault bits |
| rd_rxerr_i | input | 1 | Read strobe for receive error counter |
| rd_msstat_i | input | 1 | Read strobe for master/slave status and idle error counter |
| link_o | output | 1 | Link qualified by the idle watchdog |
| link_stat_o | output | 1 | Latched-low link status |
| rfault_o | output | 1 | Latched-high remote fault |
| jabber_o | output | 1 | Latched-high jabber |
| rx_err_cnt_o | output | RXW | Saturating receive error count |
| idle_err_cnt_o | output | IEW | Saturating idle error count |
| ms_fault_o | output | 1 | Master/slave configuration fault |
| lock_lost_o | output | 1 | Link lock lost on idle timeout |

## Verification
The link is dropped for a single cycle and then restored, which separates a true latch-low from a bit that only follows the link. The counters are driven to their ceilings and one pulse past them, which separates saturation from wrap-around. The counters also get a pulse in the same cycle as their read, which separates a kept event from a dropped one. Failure pulses are given six and then seven at a time, and then one after each kind of clear, which pins down both the threshold and the reset of the hidden failure count. Idle patterns are withheld for one cycle short of the window and for exactly the window, which locates the timeout edge.

// File: rtl/phy_status_latch.sv
module phy_status_latch #(
  parameter int RXW        = 16,
  parameter int IEW        = 8,
  parameter int FAIL_LIMIT = 7,
  parameter int IDLE_WIN   = 125000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           link_up_i,
  input  logic           idle_seen_i,
  input  logic           rx_err_i,
  input  logic           idle_err_i,
  input  logic           rfault_i,
  input  logic           jabber_i,
  input  logic           ms_fail_i,
  input  logic           ms_conflict_i,
  input  logic           an_enable_i,
  input  logic           an_done_i,
  input  logic           rd_status_i,
  input  logic           rd_rxerr_i,
  input  logic           rd_msstat_i,
  output logic           link_o,
  output logic           link_stat_o,
  output logic           rfault_o,
  output logic           jabber_o,
  output logic [RXW-1:0] rx_err_cnt_o,
  output logic [IEW-1:0] idle_err_cnt_o,
  output logic           ms_fault_o,
  output logic           lock_lost_o
);
  localparam int FW = $clog2(FAIL_LIMIT + 1);
  localparam int WW = $clog2(IDLE_WIN + 1);
  localparam logic [FW-1:0] FAIL_MAX  = FW'(FAIL_LIMIT);
  localparam logic [WW-1:0] WIN_LAST  = WW'(IDLE_WIN - 1);

  logic [FW-1:0] fail_cnt;
  logic [WW-1:0] wd_cnt;
  logic          ms_clr;

  assign link_o = link_up_i & ~lock_lost_o;
  assign ms_clr = rd_msstat_i | an_enable_i | an_done_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_stat_o <= 1'b0;
      rfault_o    <= 1'b0;
      jabber_o    <= 1'b0;
    end else if (rd_status_i) begin
      link_stat_o <= link_o;
      rfault_o    <= rfault_i;
      jabber_o    <= jabber_i;
    end else begin
      link_stat_o <= link_stat_o & link_o;
      rfault_o    <= rfault_o | rfault_i;
      jabber_o    <= jabber_o | jabber_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rx_err_cnt_o <= '0;
    else if (rd_rxerr_i)
      rx_err_cnt_o <= RXW'(rx_err_i);
    else if (rx_err_i && rx_err_cnt_o != '1)
      rx_err_cnt_o <= rx_err_cnt_o + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      idle_err_cnt_o <= '0;
    else if (rd_msstat_i)
      idle_err_cnt_o <= IEW'(idle_err_i);
    else if (idle_err_i && idle_err_cnt_o != '1)
      idle_err_cnt_o <= idle_err_cnt_o + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ms_clr) begin
      fail_cnt   <= '0;
      ms_fault_o <= 1'b0;
    end else begin
      if (ms_fail_i && fail_cnt != FAIL_MAX)
        fail_cnt <= fail_cnt + 1'b1;
      if (ms_conflict_i || (ms_fail_i && fail_cnt >= FAIL_MAX - 1'b1))
        ms_fault_o <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || idle_seen_i) begin
      wd_cnt      <= '0;
      lock_lost_o <= 1'b0;
    end else if (!lock_lost_o) begin
      wd_cnt <= wd_cnt + 1'b1;
      if (wd_cnt == WIN_LAST)
        lock_lost_o <= 1'b1;
    end
  end
endmodule

module phy_status_latch_chk #(
  parameter int RXW = 16,
  parameter int IEW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           idle_seen_i,
  input logic           rx_err_i,
  input logic           idle_err_i,
  input logic           rfault_i,
  input logic           ms_conflict_i,
  input logic           an_enable_i,
  input logic           an_done_i,
  input logic           rd_status_i,
  input logic           rd_rxerr_i,
  input logic           rd_msstat_i,
  input logic           link_o,
  input logic           link_stat_o,
  input logic           rfault_o,
  input logic [RXW-1:0] rx_err_cnt_o,
  input logic [IEW-1:0] idle_err_cnt_o,
  input logic           ms_fault_o,
  input logic           lock_lost_o
);
  AST_LINK_LATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_o && !rd_status_i) |=> !link_stat_o); // R1
  AST_RFAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rfault_i && !rd_status_i) |=> rfault_o); // R2
  AST_RXCNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err_cnt_o == '1 && !rd_rxerr_i) |=> rx_err_cnt_o == '1); // R3
  AST_IDLECNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_err_cnt_o == '1 && !rd_msstat_i) |=> idle_err_cnt_o == '1); // R4
  AST_CONFLICT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_conflict_i && !rd_msstat_i && !an_enable_i && !an_done_i) |=> ms_fault_o); // R6
  AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msstat_i || an_enable_i || an_done_i) |=> !ms_fault_o); // R7
  AST_IDLE_RESTORES_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    idle_seen_i |=> !lock_lost_o); // R8
  AST_READ_KEEPS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxerr_i && rx_err_i) |=> rx_err_cnt_o == RXW'(1)); // R9
endmodule

bind phy_status_latch phy_status_latch_chk #(.RXW(RXW), .IEW(IEW)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle_seen_i(idle_seen_i), .rx_err_i(rx_err_i),
  .idle_err_i(idle_err_i), .rfault_i(rfault_i), .ms_conflict_i(ms_conflict_i),
  .an_enable_i(an_enable_i), .an_done_i(an_done_i), .rd_status_i(rd_status_i),
  .rd_rxerr_i(rd_rxerr_i), .rd_msstat_i(rd_msstat_i), .link_o(link_o),
  .link_stat_o(link_stat_o), .rfault_o(rfault_o), .rx_err_cnt_o(rx_err_cnt_o),
  .idle_err_cnt_o(idle_err_cnt_o), .ms_fault_o(ms_fault_o), .lock_lost_o(lock_lost_o)
);

// File: tb/phy_status_latch_tb.sv
`timescale 1ns/1ps
module phy_status_latch_tb;
  localparam int WIN = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic link_up_i = 1'b1, idle_seen_i = 1'b1, rx_err_i = 1'b0, idle_err_i = 1'b0;
  logic rfault_i = 1'b0, jabber_i = 1'b0, ms_fail_i = 1'b0, ms_conflict_i = 1'b0;
  logic an_enable_i = 1'b0, an_done_i = 1'b0;
  logic rd_status_i = 1'b0, rd_rxerr_i = 1'b0, rd_msstat_i = 1'b0;
  logic link_o, link_stat_o, rfault_o, jabber_o, ms_fault_o, lock_lost_o;
  logic [15:0] rx_err_cnt_o;
  logic [7:0]  idle_err_cnt_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  phy_status_latch #(.IDLE_WIN(WIN)) u_dut (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic t_reset;
    chk("R10 link_stat", link_stat_o, 0);
    chk("R10 faults", {rfault_o, jabber_o, ms_fault_o, lock_lost_o}, 0);
    chk("R10 rx cnt", rx_err_cnt_o, 0);
    chk("R10 idle cnt", idle_err_cnt_o, 0);
  endtask

  task automatic t_link_latch;
    rd_status_i = 1; step(); rd_status_i = 0;
    chk("R1 reload on read", link_stat_o, 1);
    link_up_i = 0; step(); link_up_i = 1; step(3);
    chk("R1 stays low after recovery", link_stat_o, 0);
    rd_status_i = 1; step(); rd_status_i = 0;
    chk("R1 read reloads up link", link_stat_o, 1);
  endtask

  task automatic t_faults;
    rfault_i = 1; jabber_i = 1; step(); rfault_i = 0; jabber_i = 0; step(4);
    chk("R2 rfault held", rfault_o, 1);
    chk("R2 jabber held", jabber_o, 1);
    rd_status_i = 1; step(); rd_status_i = 0;
    chk("R2 cleared by read", {rfault_o, jabber_o}, 0);
  endtask

  task automatic t_rx_cnt;
    rx_err_i = 1; step(5); rx_err_i = 0;
    chk("R3 count", rx_err_cnt_o, 5);
    rd_rxerr_i = 1; step(); rd_rxerr_i = 0;
    chk("R3 clear on read", rx_err_cnt_o, 0);
    rd_rxerr_i = 1; rx_err_i = 1; step(); rd_rxerr_i = 0; rx_err_i = 0;
    chk("R9 event kept at read", rx_err_cnt_o, 1);
    rx_err_i = 1; step(65534);
    chk("R3 reaches ceiling", rx_err_cnt_o, 65535);
    step(3); rx_err_i = 0;
    chk("R3 no wrap", rx_err_cnt_o, 65535);
    rd_rxerr_i = 1; step(); rd_rxerr_i = 0;
  endtask

  task automatic t_idle_cnt;
    idle_err_i = 1; step(300); idle_err_i = 0;
    chk("R4 saturates", idle_err_cnt_o, 255);
    rd_msstat_i = 1; idle_err_i = 1; step(); rd_msstat_i = 0; idle_err_i = 0;
    chk("R9 idle event kept at read", idle_err_cnt_o, 1);
    rd_msstat_i = 1; step(); rd_msstat_i = 0;
    chk("R4 clear on read", idle_err_cnt_o, 0);
  endtask

  task automatic t_ms_fault;
    for (int i = 0; i < 6; i++) begin ms_fail_i = 1; step(); ms_fail_i = 0; step(); end
    chk("R5 six failures", ms_fault_o, 0);
    ms_fail_i = 1; step(); ms_fail_i = 0;
    chk("R5 seventh failure", ms_fault_o, 1);
    rd_msstat_i = 1; step(); rd_msstat_i = 0;
    chk("R7 read clears", ms_fault_o, 0);
    ms_fail_i = 1; step(); ms_fail_i = 0;
    chk("R7 fail count reset", ms_fault_o, 0);
    ms_conflict_i = 1; step(); ms_conflict_i = 0;
    chk("R6 conflict sets", ms_fault_o, 1);
    an_enable_i = 1; step(); an_enable_i = 0;
    chk("R7 an enable clears", ms_fault_o, 0);
    ms_conflict_i = 1; step(); ms_conflict_i = 0;
    an_done_i = 1; ms_conflict_i = 1; step(); an_done_i = 0; ms_conflict_i = 0;
    chk("R7 an done clears over set", ms_fault_o, 0);
  endtask

  task automatic t_watchdog;
    idle_seen_i = 0; step(WIN - 1);
    chk("R8 lock held before window", lock_lost_o, 0);
    chk("R8 link up before window", link_o, 1);
    step();
    chk("R8 lock lost at window", lock_lost_o, 1);
    chk("R8 link forced down", link_o, 0);
    step(2);
    chk("R1 latched link low", link_stat_o, 0);
    idle_seen_i = 1; step();
    chk("R8 idle restores lock", lock_lost_o, 0);
    chk("R8 link restored", link_o, 1);
  endtask

  initial begin
    #100000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step();
    t_reset();
    t_link_latch();
    t_faults();
    t_rx_cnt();
    t_idle_cnt();
    t_ms_fault();
    t_watchdog();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule